// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block turns the engine clock into the two timing strobes that a UART transmitter and receiver need. A prescaler divides the clock by a programmable 16-bit divisor plus two and emits a one-clock sample tick. A second counter counts those sample ticks and emits a bit tick once every M of them. M is the oversampling factor, so the bit rate is f_clk / (M x (divisor + 2)).

Two mode inputs select M:

| Mode | Condition | M |
|---|---|---|
| Fixed | `x_en` = 0 (`m_one` is ignored) | 16 |
| Programmable | `x_en` = 1, `m_one` = 0 | `x_val` + 1 |
| Unity | `x_en` = 1, `m_one` = 1 | 1 |

Intended settings:
- In programmable mode, `x_val` is meant to be 8.
- In unity mode, the divisor is meant to be 3.
- When the serial line drives an infrared encoder, fixed mode is required.

These settings are usage rules. The block does not enforce them.

A small state machine supervises both counters. It has two states:
- **ST_RESTART** holds both counters at zero and keeps both ticks low.
- **ST_COUNT** lets both counters run.

It has three transitions:
- *reset entry*: reset puts the machine in ST_RESTART.
- *settle*: ST_RESTART moves to ST_COUNT when the configuration is unchanged.
- *reprogram*: any state moves to ST_RESTART when the divisor, X value or either mode bit differs from its registered copy. The counters clear on that same edge.

Top module: `uart_tick_gen`

## Requirements
- R1: While `rst_n` is low, `samp_tick` and `bit_tick` are both 0.
- R2: In ST_COUNT, `samp_tick` is a single-clock pulse that repeats every `div_val` + 2 clocks.
- R3: With `x_en` = 0, a bit tick occurs on every 16th sample tick, whatever the value of `m_one`.
- R4: With `x_en` = 1 and `m_one` = 0, a bit tick occurs on every (`x_val` + 1)th sample tick. When `x_val` = 0 this means every sample tick.
- R5: With `x_en` = 1 and `m_one` = 1, a bit tick occurs on every sample tick.
- R6: `bit_tick` is high only in a cycle where `samp_tick` is also high.
- R7: When any configuration input changes, both counters restart from zero. Counting the clock edge at which the new value is first present as edge 0, the first sample tick is seen after edge `div_val` + 2. The first bit tick coincides with the M-th sample tick after that edge.
- R8: In the cycle after a configuration change (the ST_RESTART cycle), both ticks are 0.
- R9: With `div_val` = 0, sample ticks arrive every 2 clocks. With `x_val` = 15 in programmable mode, the bit period is 16 sample ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | 16 | Prescale divisor; the sample period is div_val + 2 clocks |
| x_val | input | 4 | Programmable oversampling value; M = x_val + 1 |
| x_en | input | 1 | 0 selects M = 16; 1 selects the programmable or unity factor |
| m_one | input | 1 | When x_en = 1, selects M = 1 |
| samp_tick | output | 1 | One-clock sample strobe |
| bit_tick | output | 1 | One-clock bit strobe, aligned with a sample tick |

## Verification
The bench reprograms the block in the middle of a running period. It then checks that the first sample tick lands exactly `div_val` + 2 edges after the change. A design that did not restart its counters would emit a stale early tick, and one that skipped the restart cycle would land one clock early.

In unity mode, in programmable mode with `x_val` = 0, and in fixed mode with `m_one` set, the bench measures the bit period. A design that decoded the mode priority wrongly would give a bit period of 1 or 16 where the other is expected.

`div_val` = 0 probes an off-by-one in the prescaler's terminal count, which would produce a period of 1 or 3 clocks. Every bit tick that appears without a sample tick is counted as a failure.

// File: rtl/uart_tick_pkg.sv
package uart_tick_pkg;
    typedef enum logic {
        ST_RESTART = 1'b0,
        ST_COUNT   = 1'b1
    } tick_state_e;
endpackage

// File: rtl/tick_ctrl_fsm.sv
module tick_ctrl_fsm
    import uart_tick_pkg::*;
#(
    parameter int CFG_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    output logic             run,
    output logic             clear
);
    tick_state_e      state_q, state_d;
    logic [CFG_W-1:0] cfg_q;
    logic             changed;

    assign changed = (cfg != cfg_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESTART;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESTART: state_d = changed ? ST_RESTART : ST_COUNT;
            ST_COUNT:   state_d = changed ? ST_RESTART : ST_COUNT;
            default:    state_d = ST_RESTART;
        endcase
    end

    // outputs
    always_comb begin
        clear = changed;
        run   = (state_q == ST_COUNT) && !changed;
    end

    // R7: a reprogram always lands in ST_RESTART
    p_reprogram_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> (state_q == ST_RESTART));
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             run,
    input  logic             clear,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last = {1'b0, div_val} + CNT_W'(1);
    assign tick = run && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    p_samp_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt_q <= last));
endmodule

// File: rtl/tick_bit_counter.sv
module tick_bit_counter #(
    parameter int MW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] m_last,
    input  logic          samp,
    input  logic          clear,
    output logic          tick
);
    logic [MW-1:0] cnt_q;

    assign tick = samp && (cnt_q == m_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (samp) begin
            cnt_q <= (cnt_q == m_last) ? '0 : cnt_q + MW'(1);
        end
    end

    p_bitcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt_q <= m_last));
endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int DIV_W   = 16,
    parameter int X_W     = 4,
    parameter int FIXED_M = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic [X_W-1:0]   x_val,
    input  logic             x_en,
    input  logic             m_one,
    output logic             samp_tick,
    output logic             bit_tick
);
    localparam int FM_W   = $clog2(FIXED_M);
    localparam int MW     = ((FM_W > X_W) ? FM_W : X_W) + 1;
    localparam int CFG_W  = DIV_W + X_W + 2;
    localparam logic [MW-1:0] FIX_LAST = MW'(FIXED_M - 1);

    logic             run, clear;
    logic [MW-1:0]    m_last;
    logic [CFG_W-1:0] cfg;

    assign cfg = {div_val, x_val, x_en, m_one};

    // mode decode: x_en gates m_one
    always_comb begin
        if (!x_en)      m_last = FIX_LAST;
        else if (m_one) m_last = '0;
        else            m_last = MW'(x_val);
    end

    tick_ctrl_fsm #(.CFG_W(CFG_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (cfg),
        .run   (run),
        .clear (clear)
    );

    tick_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_val),
        .run     (run),
        .clear   (clear),
        .tick    (samp_tick)
    );

    tick_bit_counter #(.MW(MW)) u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .m_last (m_last),
        .samp   (samp_tick),
        .clear  (clear),
        .tick   (bit_tick)
    );

    p_bit_on_samp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> samp_tick);
    p_quiet_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!samp_tick && !bit_tick));
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!samp_tick && !bit_tick);
        end
    end
endmodule

// File: tb/test_uart_tick_gen.sv
module test_uart_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_val = 16'd0;
    logic [3:0]  x_val = 4'd0;
    logic        x_en = 1'b0;
    logic        m_one = 1'b0;
    logic        samp_tick, bit_tick;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tick_gen i_uart_tick_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_val   (div_val),
        .x_val     (x_val),
        .x_en      (x_en),
        .m_one     (m_one),
        .samp_tick (samp_tick),
        .bit_tick  (bit_tick)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // programs a configuration and measures the first two sample and bit ticks
    task automatic run_case(input string req, input int d, input int xv, input bit xe, input bit mo);
        int m;
        int c0, s1, s2, b1, b2, orphan, early;
        int exp_s1, exp_b1, exp_b2;
        m = xe ? (mo ? 1 : xv + 1) : 16;
        @(negedge clk);
        c0 = cyc;
        div_val = 16'(d);
        x_val = 4'(xv);
        x_en = xe;
        m_one = mo;
        s1 = -1; s2 = -1; b1 = -1; b2 = -1; orphan = 0; early = 0;
        exp_s1 = c0 + d + 3;
        exp_b1 = exp_s1 + (m - 1) * (d + 2);
        exp_b2 = exp_b1 + m * (d + 2);
        for (int i = 0; i < exp_b2 - c0 + 4; i++) begin
            @(negedge clk);
            if (cyc == c0 + 1 && (samp_tick || bit_tick)) early++;
            if (samp_tick) begin
                if (s1 < 0) s1 = cyc;
                else if (s2 < 0) s2 = cyc;
            end
            if (bit_tick) begin
                if (b1 < 0) b1 = cyc;
                else if (b2 < 0) b2 = cyc;
                if (!samp_tick) orphan++;
            end
        end
        check({req, " R7"}, "first sample tick cycle", s1, exp_s1);
        check({req, " R2"}, "sample period", s2 - s1, d + 2);
        check(req, "first bit tick cycle", b1, exp_b1);
        check(req, "bit period", b2 - b1, m * (d + 2));
        check("R6", "bit ticks without sample tick", orphan, 0);
        check("R8", "ticks in restart cycle", early, 0);
    endtask

    task automatic t_reset;
        int bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (samp_tick || bit_tick) bad++;
        end
        check("R1", "ticks during reset", bad, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_fixed16;
        run_case("R3", 5, 2, 1'b0, 1'b1);
    endtask

    task automatic t_xdiv;
        run_case("R4", 3, 8, 1'b1, 1'b0);
        run_case("R4", 1, 3, 1'b1, 1'b0);
        run_case("R4", 2, 0, 1'b1, 1'b0);
    endtask

    task automatic t_unity;
        run_case("R5", 3, 8, 1'b1, 1'b1);
    endtask

    task automatic t_bounds;
        run_case("R9", 0, 15, 1'b1, 1'b0);
    endtask

    task automatic t_restart_mid;
        @(negedge clk);
        div_val = 16'd4; x_val = 4'd1; x_en = 1'b0; m_one = 1'b0;
        for (int i = 0; i < 10; i++) @(negedge clk);
        run_case("R7", 6, 5, 1'b1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_fixed16();
        t_xdiv();
        t_unity();
        t_bounds();
        t_restart_mid();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule